// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is an I2C target (slave) that runs from a fast system clock and oversamples the two bus lines. It recognises Start and Stop conditions and compares the first byte after a Start against a 7-bit own address. It then either receives data bytes from the bus controller or transmits bytes to it. It drives the bus only through two active-high "pull low" enables: one for SDA and one for SCL.

Received bytes, including the matched address byte, leave the block on a valid/ready stream. `rx_valid` is the receive-buffer-full flag. It stays high with `rx_data` steady until the host takes the byte with `rx_ready`. Transmit bytes enter on a second valid/ready stream. `tx_ready` is high only while the block holds SCL low during a read and has not yet taken a byte; a byte moves when `tx_valid` and `tx_ready` are both high on a clock edge.

The remaining pins are plain status and control signals:
- direction flag `dir_read`;
- overflow flag `overflow`, with its clear input;
- per-byte interrupt flag `byte_irq`, with its clear input;
- stretch-enable input `stretch_en`;
- single-cycle `clk_release` pulse, which sets an internal release bit.

The block holds SCL low after every matched read address and after every master acknowledge during a read. When stretch-enable is set, it also holds SCL low after every received byte. The hold lasts until the host has released it.

Top module: `isl_slave`

## Requirements
- R1: After reset, and after any Stop (SDA rising while SCL is high), both bus enables are low and the block is idle. A Start (SDA falling while SCL is high) begins reception of an address byte.
- R2: The address byte is shifted in MSB first. Bits 7:1 are the address and bit 0 is the direction bit (1 = read). On a match with bit 0 = 0, the block pulls SDA low for the ninth clock, loads the whole byte into `rx_data`, raises `rx_valid`, and clears `dir_read`.
- R3: On a match with bit 0 = 1, the block acknowledges, loads the byte into `rx_data`, and sets `dir_read`. After the ninth clock it holds SCL low whatever `stretch_en` is. It releases SCL only once a transmit byte has been accepted and the release bit is set, in either order. `tx_ready` is high only during this hold.
- R4: Transmit bytes go out MSB first. The SDA enable changes only while SCL is low.
- R5: The block does not acknowledge an address byte that does not match, or that completes while `rx_valid` or `overflow` is already set. It then returns to idle.
- R6: `byte_irq` sets at the falling edge of the ninth SCL pulse of every acknowledged byte, and of every byte transmitted to the master. It stays set until `byte_irq_clr`.
- R7: With `stretch_en` = 1, SCL is held low after every received byte until the release bit is set. With `stretch_en` = 0, received bytes cause no hold.
- R8: During a read, the block samples SDA at the rising edge of the ninth clock. A high level (NACK) returns it to idle with `dir_read` cleared and SCL free. A low level (ACK) starts a new hold with `tx_ready` high.
- R9: A data byte that completes while `rx_valid` is set is not acknowledged and sets `overflow`. `rx_data` keeps its old byte. `rx_ready` clears `rx_valid`. Only `overflow_clr` clears `overflow`.
- R10: The release bit clears whenever a hold begins, so a `clk_release` pulse given before the hold does not end it.
- R11: A Stop in the middle of a byte returns the block to idle with no byte delivered, and the next transaction is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low (clock hold) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Address this target answers to |
| stretch_en | input | 1 | Hold SCL after each received byte |
| clk_release | input | 1 | Pulse that sets the release bit |
| rx_data | output | 8 | Receive buffer |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Host takes the receive byte |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block will take a transmit byte |
| dir_read | output | 1 | Current transfer is a read |
| overflow | output | 1 | A byte arrived while the buffer was full |
| overflow_clr | input | 1 | Clear `overflow` |
| byte_irq | output | 1 | Per-byte interrupt flag |
| byte_irq_clr | input | 1 | Clear `byte_irq` |

## Verification
Each pattern checks a different part of the address and acknowledge decision:
- A matching write address followed by a data byte shows that the block accepts a transfer.
- A foreign address shows that it rejects one.
- Leaving the buffer full, or leaving overflow set, shows that a correct address is still refused while the host has unfinished work.

Reads are tried in three ways: with a release pulse before any transmit byte, with a master ACK, and with a master NACK. Together these show that the hold needs both the byte and the release, and that only a NACK ends the transfer. Writes run with stretch-enable off and on, with one release pulse given early, and one transfer is cut by a Stop halfway through a byte.

// File: rtl/isl_pkg.sv
package isl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_HOLD,
    ST_TX,
    ST_MACK
  } isl_state_e;
endpackage

// File: rtl/isl_line_sync.sv
module isl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // One extra stage beyond the synchroniser holds the previous level for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/isl_bus_cond.sv
module isl_bus_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  // SDA may only move while SCL is high to signal Start or Stop
  assign start_o = sda_fall & scl_lvl;
  assign stop_o  = sda_rise & scl_lvl;
endmodule

// File: rtl/isl_slave.sv
module isl_slave #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              stretch_en,
  input  logic              clk_release,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [ADDR_W:0]   tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              dir_read,
  output logic              overflow,
  input  logic              overflow_clr,
  output logic              byte_irq,
  input  logic              byte_irq_clr
);
  import isl_pkg::*;

  localparam int DATA_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  // Index 0 carries SCL, index 1 carries SDA
  logic [1:0] line_in, lvl, rise, fall;
  logic       start_det, stop_det;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    isl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_in[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  isl_bus_cond u_cond (
    .scl_lvl  (lvl[0]),
    .sda_rise (rise[1]),
    .sda_fall (fall[1]),
    .start_o  (start_det),
    .stop_o   (stop_det)
  );

  isl_state_e         st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  rx_sh_q, rx_buf_q, tx_sh_q;
  logic               addr_ph_q, full_q, ovf_q, dir_q, irq_q, rel_q, tx_have_q, mack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      rx_sh_q   <= '0;
      rx_buf_q  <= '0;
      tx_sh_q   <= '0;
      addr_ph_q <= 1'b0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      dir_q     <= 1'b0;
      irq_q     <= 1'b0;
      rel_q     <= 1'b0;
      tx_have_q <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      // Host side: later bus-side assignments below take precedence
      if (rx_ready && full_q) full_q <= 1'b0;
      if (overflow_clr)       ovf_q  <= 1'b0;
      if (byte_irq_clr)       irq_q  <= 1'b0;
      if (clk_release)        rel_q  <= 1'b1;
      if (tx_valid && tx_ready) begin
        tx_sh_q   <= tx_data;
        tx_have_q <= 1'b1;
      end

      if (stop_det) begin
        st_q <= ST_IDLE;
      end else if (start_det) begin
        st_q      <= ST_RX;
        cnt_q     <= '0;
        addr_ph_q <= 1'b1;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (rise[0]) begin
              rx_sh_q <= {rx_sh_q[DATA_W-2:0], lvl[1]};
              cnt_q   <= cnt_q + 1'b1;
            end else if (fall[0] && cnt_q == CNT_W'(DATA_W)) begin
              if (addr_ph_q) begin
                if (rx_sh_q[DATA_W-1 -: ADDR_W] == own_addr && !full_q && !ovf_q) begin
                  rx_buf_q <= rx_sh_q;
                  full_q   <= 1'b1;
                  dir_q    <= rx_sh_q[0];
                  st_q     <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (full_q) begin
                ovf_q <= 1'b1;
                st_q  <= ST_IDLE;
              end else begin
                rx_buf_q <= rx_sh_q;
                full_q   <= 1'b1;
                st_q     <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (fall[0]) begin
              irq_q     <= 1'b1;
              addr_ph_q <= 1'b0;
              cnt_q     <= '0;
              if (dir_q || stretch_en) begin
                st_q      <= ST_HOLD;
                rel_q     <= 1'b0;
                tx_have_q <= 1'b0;
              end else begin
                st_q <= ST_RX;
              end
            end
          end
          ST_HOLD: begin
            if (rel_q && (!dir_q || tx_have_q)) begin
              cnt_q <= '0;
              st_q  <= dir_q ? ST_TX : ST_RX;
            end
          end
          ST_TX: begin
            if (fall[0]) begin
              if (cnt_q == CNT_W'(DATA_W - 1)) begin
                st_q <= ST_MACK;
              end else begin
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (rise[0]) begin
              mack_q <= lvl[1];
            end else if (fall[0]) begin
              irq_q <= 1'b1;
              cnt_q <= '0;
              if (mack_q) begin
                st_q  <= ST_IDLE;
                dir_q <= 1'b0;
              end else begin
                st_q      <= ST_HOLD;
                rel_q     <= 1'b0;
                tx_have_q <= 1'b0;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_drive_low = (st_q == ST_HOLD);
  assign sda_drive_low = (st_q == ST_ACK) || (st_q == ST_TX && !tx_sh_q[DATA_W-1]);
  assign tx_ready      = (st_q == ST_HOLD) && dir_q && !tx_have_q;
  assign rx_data       = rx_buf_q;
  assign rx_valid      = full_q;
  assign dir_read      = dir_q;
  assign overflow      = ovf_q;
  assign byte_irq      = irq_q;
endmodule

// File: rtl/isl_slave_chk.sv
module isl_slave_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_i,
  input logic                scl_drive_low,
  input logic                sda_drive_low,
  input logic                tx_ready,
  input logic                dir_read,
  input logic                rx_valid,
  input logic                overflow,
  input logic                byte_irq,
  input logic                byte_irq_clr,
  input isl_pkg::isl_state_e st_q,
  input logic                rel_q,
  input logic                stop_det
);
  import isl_pkg::*;

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_IDLE |-> !scl_drive_low && !sda_drive_low); // R1

  AST_TXREADY_IN_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> scl_drive_low && dir_read); // R3

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i && $past(scl_i) |-> $stable(sda_drive_low)); // R4

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_ACK && $past(st_q) != ST_ACK |-> !$past(rx_valid) && !$past(overflow)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq && !byte_irq_clr |=> byte_irq); // R6

  AST_HOLD_ENDS_BY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(rel_q) || $past(stop_det)); // R10
endmodule

bind isl_slave isl_slave_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .tx_ready      (tx_ready),
  .dir_read      (dir_read),
  .rx_valid      (rx_valid),
  .overflow      (overflow),
  .byte_irq      (byte_irq),
  .byte_irq_clr  (byte_irq_clr),
  .st_q          (st_q),
  .rel_q         (rel_q),
  .stop_det      (stop_det)
);

// File: tb/isl_slave_tb.sv
module isl_slave_tb_top;
  localparam int Q = 20;
  localparam logic [6:0] MY_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_drive_low, sda_drive_low;
  logic stretch_en = 1'b0, clk_release = 1'b0;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
  logic dir_read, overflow, overflow_clr = 1'b0, byte_irq, byte_irq_clr = 1'b0;
  int checks = 0, errors = 0;

  wire scl_line = !(m_scl_low || scl_drive_low);
  wire sda_line = !(m_sda_low || sda_drive_low);

  always #4 clk = ~clk;

  isl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(MY_ADDR), .stretch_en(stretch_en), .clk_release(clk_release),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .dir_read(dir_read), .overflow(overflow), .overflow_clr(overflow_clr),
    .byte_irq(byte_irq), .byte_irq_clr(byte_irq_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wclk(Q);
    m_sda_low = 1'b1; wclk(Q);
    m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wclk(Q);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wclk(Q);
    m_sda_low = 1'b0; wclk(Q);
  endtask

  task automatic m_clock(output logic smp);
    wclk(Q / 2);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wclk(Q / 2);
    smp = sda_line;
    wclk(Q / 2);
    m_scl_low = 1'b1;
    wclk(Q);
  endtask

  task automatic m_write_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i];
      m_clock(s);
    end
    m_sda_low = 1'b0;
    m_clock(s);
    acked = !s;
  endtask

  task automatic m_read_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_clock(s);
      b = {b[6:0], s};
    end
    m_sda_low = give_ack;
    m_clock(s);
    m_sda_low = 1'b0;
  endtask

  task automatic pulse_pop();     rx_ready = 1'b1;     wclk(1); rx_ready = 1'b0;     wclk(2); endtask
  task automatic pulse_release(); clk_release = 1'b1;  wclk(1); clk_release = 1'b0;  wclk(2); endtask
  task automatic pulse_irq_clr(); byte_irq_clr = 1'b1; wclk(1); byte_irq_clr = 1'b0; wclk(2); endtask
  task automatic push_tx(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1; wclk(1); tx_valid = 1'b0; wclk(2);
  endtask

  task automatic t_reset();
    chk("R1 reset scl", scl_drive_low, 0);
    chk("R1 reset sda", sda_drive_low, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R6 reset irq", byte_irq, 0);
    chk("R3 reset tx_ready", tx_ready, 0);
  endtask

  task automatic t_write_plain();
    logic a;
    stretch_en = 1'b0;
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R2 write addr ack", a, 1);
    chk("R2 addr in buffer", rx_data, {MY_ADDR, 1'b0});
    chk("R2 rx_valid", rx_valid, 1);
    chk("R2 dir write", dir_read, 0);
    chk("R6 irq after addr", byte_irq, 1);
    chk("R7 no hold with stretch off", scl_drive_low, 0);
    pulse_pop(); pulse_irq_clr();
    chk("R9 pop clears rx_valid", rx_valid, 0);
    chk("R6 irq cleared", byte_irq, 0);
    m_write_byte(8'h5A, a);
    chk("R2 data ack", a, 1);
    chk("R2 data byte", rx_data, 8'h5A);
    chk("R6 irq after data", byte_irq, 1);
    pulse_pop(); pulse_irq_clr();
    m_stop();
    chk("R1 stop frees scl", scl_drive_low, 0);
    chk("R1 stop frees sda", sda_drive_low, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    m_start();
    m_write_byte({7'h13, 1'b0}, a);
    chk("R5 foreign addr nack", a, 0);
    chk("R5 foreign addr no data", rx_valid, 0);
    chk("R6 foreign addr no irq", byte_irq, 0);
    m_stop();
  endtask

  task automatic t_write_stretch();
    logic a;
    stretch_en = 1'b1;
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R7 addr ack", a, 1);
    chk("R7 hold after received byte", scl_drive_low, 1);
    pulse_pop(); pulse_irq_clr();
    wclk(10);
    chk("R7 still held before release", scl_drive_low, 1);
    pulse_release();
    chk("R7 released", scl_drive_low, 0);
    pulse_release();
    m_write_byte(8'hC3, a);
    chk("R7 data ack", a, 1);
    chk("R10 early release does not end hold", scl_drive_low, 1);
    chk("R7 data byte", rx_data, 8'hC3);
    pulse_pop(); pulse_irq_clr(); pulse_release();
    chk("R10 release ends hold", scl_drive_low, 0);
    m_stop();
    stretch_en = 1'b0;
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b;
    m_start();
    m_write_byte({MY_ADDR, 1'b1}, a);
    chk("R3 read addr ack", a, 1);
    chk("R3 dir read", dir_read, 1);
    chk("R3 addr in buffer", rx_data, {MY_ADDR, 1'b1});
    chk("R3 hold with stretch off", scl_drive_low, 1);
    chk("R3 tx_ready", tx_ready, 1);
    pulse_pop(); pulse_irq_clr();
    pulse_release();
    wclk(10);
    chk("R3 release alone keeps hold", scl_drive_low, 1);
    push_tx(8'h3C);
    chk("R3 byte taken", tx_ready, 0);
    chk("R3 hold ends after byte and release", scl_drive_low, 0);
    m_read_byte(1'b1, b);
    chk("R4 first byte MSB first", b, 8'h3C);
    chk("R6 irq after tx byte", byte_irq, 1);
    chk("R8 master ack holds again", scl_drive_low, 1);
    chk("R8 master ack tx_ready", tx_ready, 1);
    pulse_irq_clr();
    push_tx(8'hC9);
    pulse_release();
    m_read_byte(1'b0, b);
    chk("R4 second byte", b, 8'hC9);
    chk("R8 nack clears dir", dir_read, 0);
    chk("R8 nack frees scl", scl_drive_low, 0);
    chk("R8 nack no tx_ready", tx_ready, 0);
    chk("R6 irq after last byte", byte_irq, 1);
    pulse_irq_clr();
    m_stop();
  endtask

  task automatic t_overflow();
    logic a;
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R2 addr ack", a, 1);
    pulse_irq_clr();
    m_write_byte(8'h77, a);
    chk("R9 byte while full nack", a, 0);
    chk("R9 overflow set", overflow, 1);
    chk("R9 buffer kept", rx_data, {MY_ADDR, 1'b0});
    m_stop();
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R5 addr refused while full", a, 0);
    m_stop();
    pulse_pop();
    chk("R9 overflow survives pop", overflow, 1);
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R5 addr refused while overflow", a, 0);
    m_stop();
    overflow_clr = 1'b1; wclk(1); overflow_clr = 1'b0; wclk(2);
    chk("R9 overflow cleared", overflow, 0);
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R5 addr accepted again", a, 1);
    pulse_pop(); pulse_irq_clr();
    m_stop();
  endtask

  task automatic t_stop_midbyte();
    logic a, s;
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    pulse_pop(); pulse_irq_clr();
    for (int i = 0; i < 3; i++) begin
      m_sda_low = i[0];
      m_clock(s);
    end
    m_stop();
    chk("R11 lines free after cut", {scl_drive_low, sda_drive_low}, 0);
    chk("R11 no byte delivered", rx_valid, 0);
    chk("R11 no irq", byte_irq, 0);
    m_start();
    m_write_byte({MY_ADDR, 1'b0}, a);
    chk("R11 next transaction acked", a, 1);
    pulse_pop(); pulse_irq_clr();
    m_stop();
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_write_plain();
    t_mismatch();
    t_write_stretch();
    t_read();
    t_overflow();
    t_stop_midbyte();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule